// File: doc/BRIEF.md
# Instruction-Boundary Interrupt and Single-Step Arbiter

This block sits where a small 16-bit core retires one instruction and starts the next. At each retirement it decides whether an interrupt entry should begin. The candidates are a non-maskable request, a maskable request and a single-step trap. When it decides to start an entry, it issues a one-cycle strobe together with either a fixed vector or a flag. The flag tells the entry sequencer that the vector number must be read in an acknowledge cycle, after the flags have been pushed.

Two pieces of history affect each decision.

- **Shadow counter.** A short counter is loaded whenever the retiring instruction wrote a segment register. It keeps the next boundary free of all interrupts, and that includes the single-step trap.
- **Trap arming counter.** A saturating counter advances on every boundary while the trap flag is set. The trap may only fire once this counter has seen two earlier boundaries.

Stacking, vector fetch and decode live elsewhere. The core only reports the retire strobe and the segment-load pulse.

Top module: `boundary_irq_arbiter`

## Requirements
- R1: A synchronous active-high reset clears all outputs, the shadow counter and the trap arming counter. After reset, a boundary with a qualifying maskable request is taken at once, and an active trap does not fire until two further boundaries have passed.
- R2: Decisions are made only on cycles where `retire_i` is high. `take_o` is high exactly one cycle after such a cycle and is low in every other cycle. When `take_o` is low, `vec_o`, `vec_from_ack_o` and `nmi_clr_o` are all 0.
- R3: When the shadow is clear and `nmi_pend_i` is high at a boundary, an entry is taken with `vec_o` = 8'h02, `nmi_clr_o` = 1 and `vec_from_ack_o` = 0. This holds whatever the states of `intr_i` and `ien_i`.
- R4: A maskable request (`intr_i`) is taken only when `ien_i` is 1. It is signalled with `vec_from_ack_o` = 1, `vec_o` = 8'h00 and `nmi_clr_o` = 0.
- R5: A boundary where `seg_load_i` is high makes `busy_o` go high and blocks every entry at the next boundary. The shadow then counts down at that boundary, so `busy_o` returns to 0.
- R6: The shadow is counted down, or loaded, only after the checks for the same boundary. A segment load does not block an entry that qualifies at its own boundary.
- R7: While `trap_i` is high, the arming counter advances once per boundary. The single-step entry (`vec_o` = 8'h01, `vec_from_ack_o` = 0) fires at the first boundary where the count is at least 2 and the shadow is clear. Firing resets the count to 0.
- R8: At a boundary blocked by the shadow, the trap does not fire and its count still advances.
- R9: If an external entry and the trap both qualify at one boundary, the external entry is issued and the trap fires at a later boundary.
- R10: The arming count saturates at 3. It does not wrap while the shadow keeps blocking it.
- R11: A boundary with `trap_i` low clears the arming count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retire_i | input | 1 | An instruction retires this cycle (boundary) |
| nmi_pend_i | input | 1 | Non-maskable request pending |
| intr_i | input | 1 | Maskable request pending |
| ien_i | input | 1 | Interrupt-enable flag |
| trap_i | input | 1 | Single-step trap flag |
| seg_load_i | input | 1 | The retiring instruction wrote a segment register |
| take_o | output | 1 | Start an interrupt entry (one-cycle strobe) |
| vec_o | output | 8 | Vector number for NMI or trap entry, 0 otherwise |
| vec_from_ack_o | output | 1 | Vector must be fetched by an acknowledge cycle |
| nmi_clr_o | output | 1 | Clear the pending NMI |
| busy_o | output | 1 | Shadow active: the next boundary accepts no entry |

## Verification
The main decision is driven through a table of boundary patterns. Each pattern is aimed at a specific rule:

- **NMI priority.** NMI is presented alone and together with a maskable request, with the enable flag both set and clear. This shows that NMI wins over the maskable request and does not depend on the enable flag.
- **Shadow timing.** Segment loads are placed at a boundary that carries a pending request and at the boundary just before one. This separates "the load is seen after the checks" from "the load blocks the next boundary".
- **Trap arming.** Trap runs are interrupted by shadows, by external requests and by a dropped trap flag. These show that counting continues while the trap is blocked, that external entries win over the trap, and that the count clears when the flag drops.
- **Saturation.** A run of back-to-back segment loads would make a wrapping counter miss the fire, which isolates the saturation rule.

Directed tests cover reset in the middle of a run and cycles without a retire strobe.

// File: rtl/bia_pkg.sv
package bia_pkg;

  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] NMI_VECTOR  = 8'h02;
  localparam logic [VEC_W-1:0] STEP_VECTOR = 8'h01;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_INTR = 2'd2,
    SRC_STEP = 2'd3
  } entry_src_e;

  // Saturating increment used by the trap arming counter.
  function automatic int sat_inc(input int value, input int limit);
    return (value >= limit) ? limit : value + 1;
  endfunction

  // Shadow counter next value at a boundary: a load wins, otherwise count down to zero.
  function automatic int shadow_next(input int value, input bit load, input int load_val);
    if (load) return load_val;
    return (value > 0) ? value - 1 : 0;
  endfunction

  // Vector reported for each entry source; maskable entries get theirs later.
  function automatic logic [VEC_W-1:0] src_vector(input entry_src_e src);
    case (src)
      SRC_NMI:  return NMI_VECTOR;
      SRC_STEP: return STEP_VECTOR;
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/bia_shadow_ctr.sv
module bia_shadow_ctr #(
  parameter int CNT_W    = 2,
  parameter int LOAD_VAL = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  input  logic load_i,
  output logic clear_o
);
  import bia_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= CNT_W'(shadow_next(int'(cnt_q), load_i, LOAD_VAL));
    end
  end

  assign clear_o = (cnt_q == '0);

endmodule

// File: rtl/bia_trap_ctr.sv
module bia_trap_ctr #(
  parameter int CNT_W = 2,
  parameter int ARM   = 2,
  parameter int SAT   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  input  logic trap_en_i,
  input  logic fire_i,
  output logic armed_o
);
  import bia_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (step_i) begin
      if (!trap_en_i || fire_i) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= CNT_W'(sat_inc(int'(cnt_q), SAT));
      end
    end
  end

  assign armed_o = (int'(cnt_q) >= ARM);

endmodule

// File: rtl/bia_dispatch_sel.sv
module bia_dispatch_sel (
  input  logic                   retire_i,
  input  logic                   shadow_clear_i,
  input  logic                   nmi_i,
  input  logic                   intr_i,
  input  logic                   ien_i,
  input  logic                   trap_i,
  input  logic                   armed_i,
  output bia_pkg::entry_src_e    src_o,
  output logic                   ext_o,
  output logic                   step_o
);
  import bia_pkg::*;

  logic open_w;

  always_comb begin
    open_w = retire_i && shadow_clear_i;
    ext_o  = open_w && (nmi_i || (intr_i && ien_i));
    step_o = open_w && trap_i && armed_i && !ext_o;
    if (ext_o && nmi_i)  src_o = SRC_NMI;
    else if (ext_o)      src_o = SRC_INTR;
    else if (step_o)     src_o = SRC_STEP;
    else                 src_o = SRC_NONE;
  end

endmodule

// File: rtl/boundary_irq_arbiter.sv
module boundary_irq_arbiter #(
  parameter int SHADOW_W    = 2,
  parameter int SHADOW_LOAD = 1,
  parameter int TRAP_W      = 2,
  parameter int TRAP_ARM    = 2,
  parameter int TRAP_SAT    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       retire_i,
  input  logic       nmi_pend_i,
  input  logic       intr_i,
  input  logic       ien_i,
  input  logic       trap_i,
  input  logic       seg_load_i,
  output logic       take_o,
  output logic [7:0] vec_o,
  output logic       vec_from_ack_o,
  output logic       nmi_clr_o,
  output logic       busy_o
);
  import bia_pkg::*;

  logic       shadow_clear_w;
  logic       trap_armed_w;
  logic       ext_take_w;
  logic       trap_fire_w;
  entry_src_e src_w;

  bia_shadow_ctr #(.CNT_W(SHADOW_W), .LOAD_VAL(SHADOW_LOAD)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .step_i  (retire_i),
    .load_i  (seg_load_i),
    .clear_o (shadow_clear_w)
  );

  bia_trap_ctr #(.CNT_W(TRAP_W), .ARM(TRAP_ARM), .SAT(TRAP_SAT)) u_trap (
    .clk       (clk),
    .rst       (rst),
    .step_i    (retire_i),
    .trap_en_i (trap_i),
    .fire_i    (trap_fire_w),
    .armed_o   (trap_armed_w)
  );

  bia_dispatch_sel u_sel (
    .retire_i       (retire_i),
    .shadow_clear_i (shadow_clear_w),
    .nmi_i          (nmi_pend_i),
    .intr_i         (intr_i),
    .ien_i          (ien_i),
    .trap_i         (trap_i),
    .armed_i        (trap_armed_w),
    .src_o          (src_w),
    .ext_o          (ext_take_w),
    .step_o         (trap_fire_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o         <= 1'b0;
      vec_o          <= '0;
      vec_from_ack_o <= 1'b0;
      nmi_clr_o      <= 1'b0;
    end else begin
      take_o         <= (src_w != SRC_NONE);
      vec_o          <= src_vector(src_w);
      vec_from_ack_o <= (src_w == SRC_INTR);
      nmi_clr_o      <= (src_w == SRC_NMI);
    end
  end

  assign busy_o = !shadow_clear_w;

endmodule

// File: rtl/bia_checker.sv
module bia_checker (
  input logic       clk,
  input logic       rst,
  input logic       retire_i,
  input logic       nmi_pend_i,
  input logic       ien_i,
  input logic       trap_i,
  input logic       seg_load_i,
  input logic       take_o,
  input logic [7:0] vec_o,
  input logic       vec_from_ack_o,
  input logic       nmi_clr_o,
  input logic       busy_o,
  input logic       ext_take_w,
  input logic       trap_fire_w
);

  // R2
  take_needs_retire_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(retire_i));

  // R2
  idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> (vec_o == 8'h00 && !vec_from_ack_o && !nmi_clr_o));

  // R3
  nmi_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !busy_o && nmi_pend_i) |=> (take_o && nmi_clr_o && vec_o == 8'h02 && !vec_from_ack_o));

  // R4
  intr_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && vec_from_ack_o) |-> $past(ien_i));

  // R5
  shadow_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && busy_o) |=> !take_o);

  // R5
  seg_load_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && seg_load_i) |=> busy_o);

  // R7
  step_needs_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && vec_o == 8'h01) |-> $past(trap_i));

  // R9
  one_source_chk: assert property (@(posedge clk) disable iff (rst)
    !(ext_take_w && trap_fire_w));

endmodule

bind boundary_irq_arbiter bia_checker chk_i (
  .clk            (clk),
  .rst            (rst),
  .retire_i       (retire_i),
  .nmi_pend_i     (nmi_pend_i),
  .ien_i          (ien_i),
  .trap_i         (trap_i),
  .seg_load_i     (seg_load_i),
  .take_o         (take_o),
  .vec_o          (vec_o),
  .vec_from_ack_o (vec_from_ack_o),
  .nmi_clr_o      (nmi_clr_o),
  .busy_o         (busy_o),
  .ext_take_w     (ext_take_w),
  .trap_fire_w    (trap_fire_w)
);

// File: tb/boundary_irq_arbiter_tb.sv
module boundary_irq_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       retire_i = 1'b0;
  logic       nmi_pend_i = 1'b0;
  logic       intr_i = 1'b0;
  logic       ien_i = 1'b0;
  logic       trap_i = 1'b0;
  logic       seg_load_i = 1'b0;
  logic       take_o;
  logic [7:0] vec_o;
  logic       vec_from_ack_o;
  logic       nmi_clr_o;
  logic       busy_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  boundary_irq_arbiter dut_i (
    .clk            (clk),
    .rst            (rst),
    .retire_i       (retire_i),
    .nmi_pend_i     (nmi_pend_i),
    .intr_i         (intr_i),
    .ien_i          (ien_i),
    .trap_i         (trap_i),
    .seg_load_i     (seg_load_i),
    .take_o         (take_o),
    .vec_o          (vec_o),
    .vec_from_ack_o (vec_from_ack_o),
    .nmi_clr_o      (nmi_clr_o),
    .busy_o         (busy_o)
  );

  // Row: {nmi,intr,ien,trap,seg} {take,ack,clr,busy} vec
  localparam int ROWS = 35;
  localparam logic [16:0] TBL [0:ROWS-1] = '{
    {5'b01100, 4'b1100, 8'h00}, // R4 enabled maskable taken
    {5'b01000, 4'b0000, 8'h00}, // R4 disabled maskable ignored
    {5'b11100, 4'b1010, 8'h02}, // R3 NMI beats maskable
    {5'b10000, 4'b1010, 8'h02}, // R3 NMI with enable clear
    {5'b01101, 4'b1101, 8'h00}, // R6 load does not block own boundary
    {5'b01100, 4'b0000, 8'h00}, // R5 blocked, shadow expires
    {5'b01100, 4'b1100, 8'h00}, // R5 open again
    {5'b10001, 4'b1011, 8'h02}, // R6 NMI with load
    {5'b10000, 4'b0000, 8'h00}, // R5 NMI blocked
    {5'b00010, 4'b0000, 8'h00}, // R7 count 0->1
    {5'b00010, 4'b0000, 8'h00}, // R7 count 1->2
    {5'b00010, 4'b1000, 8'h01}, // R7 fires
    {5'b00010, 4'b0000, 8'h00}, // R7 rearm
    {5'b00010, 4'b0000, 8'h00},
    {5'b00011, 4'b1001, 8'h01}, // R6 trap fires with load
    {5'b00010, 4'b0000, 8'h00},
    {5'b00011, 4'b0001, 8'h00},
    {5'b00010, 4'b0000, 8'h00}, // R8 blocked, count advances
    {5'b00010, 4'b1000, 8'h01}, // R8 fires after shadow
    {5'b01110, 4'b1100, 8'h00},
    {5'b01110, 4'b1100, 8'h00},
    {5'b01110, 4'b1100, 8'h00}, // R9 external wins
    {5'b00010, 4'b1000, 8'h01}, // R9 trap follows
    {5'b00010, 4'b0000, 8'h00},
    {5'b00010, 4'b0000, 8'h00},
    {5'b00000, 4'b0000, 8'h00}, // R11 flag low clears
    {5'b00010, 4'b0000, 8'h00}, // R11 would fire if not cleared
    {5'b00010, 4'b0000, 8'h00},
    {5'b00010, 4'b1000, 8'h01},
    {5'b00011, 4'b0001, 8'h00}, // R10 start of blocked run
    {5'b00011, 4'b0001, 8'h00},
    {5'b00011, 4'b0001, 8'h00},
    {5'b00010, 4'b0000, 8'h00},
    {5'b00010, 4'b1000, 8'h01}, // R10 saturated count fires
    {5'b00000, 4'b0000, 8'h00}
  };

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got take/ack/clr/busy/vec=%b_%h expected %b_%h",
               req, got[11:8], got[7:0], exp[11:8], exp[7:0]);
    end
  endtask

  function automatic logic [11:0] outs();
    return {take_o, vec_from_ack_o, nmi_clr_o, busy_o, vec_o};
  endfunction

  task automatic boundary(input logic [4:0] ins);
    {nmi_pend_i, intr_i, ien_i, trap_i, seg_load_i} = ins;
    retire_i = 1'b1;
    @(negedge clk);
    retire_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", outs(), 12'h000);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < ROWS; k++) begin
      boundary(TBL[k][16:12]);
      check($sformatf("row %0d", k), outs(), TBL[k][11:0]);
    end

    // R2 no retire: requests present, nothing taken
    nmi_pend_i = 1'b1; intr_i = 1'b1; ien_i = 1'b1; trap_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R2 no retire", outs(), 12'h000);
    end
    boundary(5'b10000);
    check("R2 NMI at retire", outs(), {4'b1010, 8'h02});
    @(negedge clk);
    check("R2 strobe one cycle", outs(), 12'h000);

    // R1 reset mid-run clears shadow and trap count
    boundary(5'b00011);
    boundary(5'b00010);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears", outs(), 12'h000);
    boundary(5'b01100);
    check("R1 shadow cleared", outs(), {4'b1100, 8'h00});
    boundary(5'b00010);
    check("R1 trap count cleared a", outs(), 12'h000);
    boundary(5'b00010);
    check("R1 trap count cleared b", outs(), 12'h000);
    boundary(5'b00010);
    check("R1 trap fires after rearm", outs(), {4'b1000, 8'h01});

    // R4 intr with enable low and trap inactive: nothing
    boundary(5'b01000);
    check("R4 masked", outs(), 12'h000);

    finish_run();
  end

endmodule